// File: doc/BRIEF.md
# Fixed-Point Second-Order Recursive Filter Section

This block is one second-order section of a recursive filter, with two zeros and two poles. Each time the input strobe is high, it takes one signed sample. It combines that sample with the two previous inputs and the two previous outputs, weighted by five signed coefficients. The coefficients are static ports. The leading denominator term is fixed at one, so only the two feedback weights are supplied.

All five products are kept at full width and summed in a single accumulator. The accumulator has three guard bits above the product width. The total is quantized exactly once: it is rounded half-up and then saturated to the sample width. That one quantized value is both the emitted result and the value written into the output history. The result leaves through a delay line whose depth is a parameter. Longer filters are built by chaining sections.

Top module: `biquad_df1`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `out_sample` is 0. All four history registers clear, so the first result after reset equals the rounded `coef_b0 * in_sample`.
- R2: For each accepted sample, the result is y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. Here x1 and x2 are the two previous accepted inputs and y1 and y2 the two previous results. Coefficients are two's complement with `FRAC_W` fractional bits, so 16384 means 1.0 when `FRAC_W`=14.
- R3: A sample accepted on a rising edge produces exactly one `out_valid` pulse after `LATENCY` rising edges, with `LATENCY` ≥ 1. No other `out_valid` pulse occurs.
- R4: Cycles with `in_valid` low leave all history unchanged, so idle gaps do not alter any later result.
- R5: Rounding adds half an output LSB (2^(`FRAC_W`−1)) to the sum and then shifts it arithmetically right by `FRAC_W`. Exact halves therefore go toward +infinity: 0.5 becomes 1, −0.5 becomes 0, −1.5 becomes −1.
- R6: A rounded value above 2^(`SAMPLE_W`−1)−1 or below −2^(`SAMPLE_W`−1) is clamped to that limit rather than wrapped.
- R7: The value fed back as y1 is the rounded and saturated result, identical to the emitted output.
- R8: While `out_valid` is low, `out_sample` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| coef_b0 | input | COEF_W | Feed-forward weight on the current input |
| coef_b1 | input | COEF_W | Feed-forward weight on the previous input |
| coef_b2 | input | COEF_W | Feed-forward weight on the input two samples back |
| coef_a1 | input | COEF_W | Feedback weight on the previous output, subtracted |
| coef_a2 | input | COEF_W | Feedback weight on the output two samples back, subtracted |
| out_valid | output | 1 | Result strobe, `LATENCY` edges after the input strobe |
| out_sample | output | SAMPLE_W | Signed rounded and saturated result |

## Verification
Each accepted sample's result is due exactly `LATENCY` rising edges after the edge that captured it. The history registers change on that same capturing edge. The bench records the due edge index together with the expected value and samples the outputs at falling edges. At the due edge it requires the strobe and the value. At any other edge it flags a strobe as spurious and otherwise requires the output to be held. Back-to-back samples and samples separated by idle gaps both check that the feedback path is ready one edge after capture.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_COEF_W   = 16;
    localparam int DEF_FRAC_W   = 14;
    localparam int DEF_LATENCY  = 3;

    // Headroom for summing five full-width products.
    localparam int GUARD_W  = 3;
    localparam int NUM_TAPS = 5;

    // Tap order used by the multiply-accumulate array.
    typedef enum int {
        TAP_B0 = 0,
        TAP_B1 = 1,
        TAP_B2 = 2,
        TAP_A1 = 3,
        TAP_A2 = 4
    } tap_e;

    // Feedback taps are subtracted from the sum.
    function automatic bit tap_is_feedback(input int t);
        return t >= int'(TAP_A1);
    endfunction

endpackage

// File: rtl/biquad_mac.sv
module biquad_mac
    import biquad_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int COEF_W   = DEF_COEF_W,
    parameter int ACC_W    = SAMPLE_W + COEF_W + GUARD_W
) (
    input  logic signed [SAMPLE_W-1:0] tap_val  [NUM_TAPS],
    input  logic signed [COEF_W-1:0]   tap_coef [NUM_TAPS],
    output logic signed [ACC_W-1:0]    acc
);

    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [ACC_W-1:0] term [NUM_TAPS];

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        logic signed [PROD_W-1:0] prod;
        logic signed [ACC_W-1:0]  ext;
        assign prod = tap_val[i] * tap_coef[i];
        assign ext  = ACC_W'(prod);
        if (tap_is_feedback(i)) begin : g_sub
            assign term[i] = '0 - ext;
        end else begin : g_add
            assign term[i] = ext;
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            acc = acc + term[k];
        end
    end

endmodule

// File: rtl/biquad_quant.sv
module biquad_quant #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 35,
    parameter int FRAC_W   = 14
) (
    input  logic signed [ACC_W-1:0]    acc,
    output logic signed [SAMPLE_W-1:0] y
);

    localparam logic signed [ACC_W-1:0] HALF_LSB =
        {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] MAX_V =
        {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V = ~MAX_V;

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        biased = acc + HALF_LSB;
        scaled = biased >>> FRAC_W;
        if (scaled > MAX_V) begin
            y = MAX_V[SAMPLE_W-1:0];
        end else if (scaled < MIN_V) begin
            y = MIN_V[SAMPLE_W-1:0];
        end else begin
            y = scaled[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/biquad_history.sv
module biquad_history #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] x_new,
    input  logic signed [SAMPLE_W-1:0] y_new,
    output logic signed [SAMPLE_W-1:0] x_d1,
    output logic signed [SAMPLE_W-1:0] x_d2,
    output logic signed [SAMPLE_W-1:0] y_d1,
    output logic signed [SAMPLE_W-1:0] y_d2
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1 <= '0;
            x_d2 <= '0;
            y_d1 <= '0;
            y_d2 <= '0;
        end else if (en) begin
            x_d1 <= x_new;
            x_d2 <= x_d1;
            y_d1 <= y_new;
            y_d2 <= y_d1;
        end
    end

endmodule

// File: rtl/biquad_outpipe.sv
module biquad_outpipe #(
    parameter int SAMPLE_W = 16,
    parameter int LATENCY  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_y,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_y,
    output logic signed [SAMPLE_W-1:0] first_y
);

    logic                       vld_q [LATENCY];
    logic signed [SAMPLE_W-1:0] y_q   [LATENCY];

    for (genvar i = 0; i < LATENCY; i++) begin : g_stage
        logic                       src_vld;
        logic signed [SAMPLE_W-1:0] src_y;
        if (i == 0) begin : g_head
            assign src_vld = in_vld;
            assign src_y   = in_y;
        end else begin : g_body
            assign src_vld = vld_q[i-1];
            assign src_y   = y_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                y_q[i]   <= '0;
            end else begin
                vld_q[i] <= src_vld;
                if (src_vld) begin
                    y_q[i] <= src_y;
                end
            end
        end
    end

    assign out_vld = vld_q[LATENCY-1];
    assign out_y   = y_q[LATENCY-1];
    assign first_y = y_q[0];

endmodule

// File: rtl/biquad_df1.sv
module biquad_df1
    import biquad_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int COEF_W   = DEF_COEF_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter int LATENCY  = DEF_LATENCY
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic signed [COEF_W-1:0]   coef_b0,
    input  logic signed [COEF_W-1:0]   coef_b1,
    input  logic signed [COEF_W-1:0]   coef_b2,
    input  logic signed [COEF_W-1:0]   coef_a1,
    input  logic signed [COEF_W-1:0]   coef_a2,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample
);

    localparam int ACC_W = SAMPLE_W + COEF_W + GUARD_W;

    logic signed [SAMPLE_W-1:0] x_d1, x_d2, y_d1, y_d2;
    logic signed [SAMPLE_W-1:0] tap_val  [NUM_TAPS];
    logic signed [COEF_W-1:0]   tap_coef [NUM_TAPS];
    logic signed [ACC_W-1:0]    acc;
    logic signed [SAMPLE_W-1:0] y_new;
    logic signed [SAMPLE_W-1:0] stage0_y;

    always_comb begin
        tap_val[TAP_B0]  = in_sample;
        tap_val[TAP_B1]  = x_d1;
        tap_val[TAP_B2]  = x_d2;
        tap_val[TAP_A1]  = y_d1;
        tap_val[TAP_A2]  = y_d2;
        tap_coef[TAP_B0] = coef_b0;
        tap_coef[TAP_B1] = coef_b1;
        tap_coef[TAP_B2] = coef_b2;
        tap_coef[TAP_A1] = coef_a1;
        tap_coef[TAP_A2] = coef_a2;
    end

    biquad_mac #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W)
    ) u_mac (
        .tap_val  (tap_val),
        .tap_coef (tap_coef),
        .acc      (acc)
    );

    biquad_quant #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .FRAC_W   (FRAC_W)
    ) u_quant (
        .acc (acc),
        .y   (y_new)
    );

    biquad_history #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hist (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .x_new (in_sample),
        .y_new (y_new),
        .x_d1  (x_d1),
        .x_d2  (x_d2),
        .y_d1  (y_d1),
        .y_d2  (y_d2)
    );

    biquad_outpipe #(
        .SAMPLE_W (SAMPLE_W),
        .LATENCY  (LATENCY)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_y    (y_new),
        .out_vld (out_valid),
        .out_y   (out_sample),
        .first_y (stage0_y)
    );

endmodule

// File: rtl/biquad_df1_chk.sv
module biquad_df1_chk #(
    parameter int SAMPLE_W = 16,
    parameter int LATENCY  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_sample,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_sample,
    input logic signed [SAMPLE_W-1:0] x_d1,
    input logic signed [SAMPLE_W-1:0] x_d2,
    input logic signed [SAMPLE_W-1:0] y_d1,
    input logic signed [SAMPLE_W-1:0] y_d2,
    input logic signed [SAMPLE_W-1:0] stage0_y
);

    localparam int PEND_W = $clog2(LATENCY + 2) + 1;

    logic [PEND_W-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            pending <= pending + PEND_W'(in_valid) - PEND_W'(out_valid);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0 && y_d1 == '0 && x_d1 == '0));

    // R3
    no_orphan_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pending != '0));

    // R3
    pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pending <= PEND_W'(LATENCY));

    // R2
    input_shift_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (x_d1 == $past(in_sample) && x_d2 == $past(x_d1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(x_d1) && $stable(x_d2) && $stable(y_d1) && $stable(y_d2)));

    // R7
    feedback_match_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (y_d1 == stage0_y && y_d2 == $past(y_d1)));

    // R8
    output_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));

endmodule

bind biquad_df1 biquad_df1_chk #(
    .SAMPLE_W (SAMPLE_W),
    .LATENCY  (LATENCY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .x_d1       (x_d1),
    .x_d2       (x_d2),
    .y_d1       (y_d1),
    .y_d2       (y_d2),
    .stage0_y   (stage0_y)
);

// File: tb/biquad_df1_test.sv
module biquad_df1_test;

    localparam int SW  = 16;
    localparam int CW  = 16;
    localparam int FW  = 14;
    localparam int LAT = 3;
    localparam longint SMAX = (longint'(1) <<< (SW - 1)) - 1;
    localparam longint SMIN = -(longint'(1) <<< (SW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_sample = '0;
    logic signed [CW-1:0] coef_b0, coef_b1, coef_b2, coef_a1, coef_a2;
    logic                 out_valid;
    logic signed [SW-1:0] out_sample;

    longint cb0 = 0, cb1 = 0, cb2 = 0, ca1 = 0, ca2 = 0;
    longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;
    longint last_out = 0;
    int     cyc = 0;
    int     n_chk = 0;
    int     n_err = 0;
    bit     running = 1'b0;
    bit     finished = 1'b0;

    typedef struct {
        longint y;
        int     due;
        string  tag;
    } exp_t;
    exp_t exp_q[$];

    assign coef_b0 = CW'(cb0);
    assign coef_b1 = CW'(cb1);
    assign coef_b2 = CW'(cb2);
    assign coef_a1 = CW'(ca1);
    assign coef_a2 = CW'(ca2);

    biquad_df1 #(
        .SAMPLE_W (SW),
        .COEF_W   (CW),
        .FRAC_W   (FW),
        .LATENCY  (LAT)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef_b0    (coef_b0),
        .coef_b1    (coef_b1),
        .coef_b2    (coef_b2),
        .coef_a1    (coef_a1),
        .coef_a2    (coef_a2),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic longint model_step(input longint x);
        longint acc;
        longint r;
        acc = cb0 * x + cb1 * mx1 + cb2 * mx2 - ca1 * my1 - ca2 * my2;
        r = (acc + (longint'(1) <<< (FW - 1))) >>> FW;
        if (r > SMAX) r = SMAX;
        if (r < SMIN) r = SMIN;
        mx2 = mx1;
        mx1 = x;
        my2 = my1;
        my1 = r;
        return r;
    endfunction

    always @(negedge clk) begin
        if (running && !rst) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                check(out_valid === 1'b1, {exp_q[0].tag, " R3 strobe due"}, longint'(out_valid), 1);
                check($signed(out_sample) == exp_q[0].y, exp_q[0].tag,
                      longint'($signed(out_sample)), exp_q[0].y);
                last_out = longint'($signed(out_sample));
                void'(exp_q.pop_front());
            end else if (out_valid) begin
                check(1'b0, "R3 spurious strobe", 1, 0);
            end else begin
                check($signed(out_sample) == last_out, "R8 hold while idle",
                      longint'($signed(out_sample)), last_out);
            end
        end
    end

    task automatic send(input longint x, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SW'(x);
        e.y   = model_step(x);
        e.due = cyc + LAT;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        running = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        check(out_sample == '0, "R1 sample in reset", longint'($signed(out_sample)), 0);
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        last_out = 0;
        exp_q.delete();
        rst = 1'b0;
        running = 1'b1;
    endtask

    task automatic set_coefs(input longint b0, input longint b1, input longint b2,
                             input longint a1, input longint a2);
        cb0 = b0; cb1 = b1; cb2 = b2; ca1 = a1; ca2 = a2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        set_coefs(16384, 0, 0, 0, 0);
        do_reset();

        // R1: first result after reset sees zero history
        set_coefs(16384, 16384, 16384, 16384, 16384);
        send(1000, "R1 first after reset");
        idle(LAT + 3);

        // R2: identity and pure delay
        do_reset();
        set_coefs(16384, 0, 0, 0, 0);
        send(100, "R2 identity");
        send(-200, "R2 identity");
        send(32767, "R2 identity");
        send(-32768, "R2 identity");
        idle(LAT + 3);
        do_reset();
        set_coefs(0, 0, 16384, 0, 0);
        send(11, "R2 two-sample delay");
        send(22, "R2 two-sample delay");
        send(33, "R2 two-sample delay");
        send(44, "R2 two-sample delay");
        idle(LAT + 3);

        // R5: ties round toward +infinity (expected 1, 0, 2, -1)
        do_reset();
        set_coefs(8192, 0, 0, 0, 0);
        send(1, "R5 tie +0.5");
        send(-1, "R5 tie -0.5");
        send(3, "R5 tie +1.5");
        send(-3, "R5 tie -1.5");
        idle(LAT + 3);

        // R6: clamp at both limits
        do_reset();
        set_coefs(32767, 0, 0, 0, 0);
        send(32767, "R6 clamp high");
        send(-32768, "R6 clamp low");
        idle(LAT + 3);

        // R7: feedback takes the clamped value (a1 = -2.0)
        do_reset();
        set_coefs(16384, 0, 0, -32768, 0);
        send(20000, "R7 feedback");
        send(20000, "R7 feedback clamp");
        send(-30000, "R7 feedback after clamp");
        send(0, "R7 feedback");
        idle(LAT + 3);

        // R4 and R2: random coefficients and samples, random idle gaps
        do_reset();
        void'($urandom(32'd1234));
        for (int set = 0; set < 3; set++) begin
            set_coefs(longint'($urandom_range(0, 32767)) - 16384,
                      longint'($urandom_range(0, 32767)) - 16384,
                      longint'($urandom_range(0, 32767)) - 16384,
                      longint'($urandom_range(0, 32767)) - 16384,
                      longint'($urandom_range(0, 16383)) - 8192);
            for (int k = 0; k < 120; k++) begin
                send(longint'($urandom_range(0, 65535)) - 32768, "R4 random with gaps");
                idle(int'($urandom_range(0, 3)));
            end
            idle(LAT + 3);
            do_reset();
        end

        // R2: random back-to-back samples
        set_coefs(12000, -5000, 3000, -9000, 4000);
        for (int k = 0; k < 200; k++) begin
            send(longint'($urandom_range(0, 65535)) - 32768, "R2 back-to-back");
        end
        idle(LAT + 4);

        // R3: every expected result was delivered
        check(exp_q.size() == 0, "R3 all results delivered", longint'(exp_q.size()), 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule